// File: doc/BRIEF.md
# Device-Tagged Translation Cache with Invalidation

This block is a small fully associative translation cache that sits in front of the DMA remapping walker. Each translation entry maps an I/O virtual page number to a physical page number, and each entry is tagged with the 16-bit requester identity of the device that issued the access. A separate context cache maps a requester identity to the root of its page table. A lookup is answered combinationally in the cycle it is presented. On a miss the block asks for a walk, allows one walk to be outstanding, and installs the walker's result in both caches.

Software removes stale mappings through an invalidation port. The port handles four operations. An unmap can run synchronously, stalling the requester until it completes. It can also run deferred: the page is queued, keeps hitting, and is removed in a batch when the queue fills or when an explicit flush arrives. A device-wide invalidation and a global invalidation always complete in a single busy cycle. A walk whose address is invalidated while it is still in flight has its fill discarded.

Top module: `dev_iotlb`

## Requirements
- R1: After reset no lookup hits in either cache, and `inv_ready` is 1.
- R2: A lookup hits only when one valid entry matches both `lk_bdf` and `lk_vpn`. In that case `lk_hit` is 1 and `lk_ppn` gives that entry's page in the same cycle.
- R3: `walk_req` is 1 for a valid lookup that misses, but only when no walk is outstanding and the port is not busy. The clock edge on which `walk_req` is 1 records the lookup's identity and page as the single outstanding walk.
- R4: A `fill_valid` pulse while a walk is outstanding ends that walk. A fill that is not discarded installs (walk identity, walk page, `fill_ppn`) and is visible from the next cycle. The 16 translation slots are replaced round-robin, so the 17th of 17 consecutive fills evicts the first of them.
- R5: A fill that is not discarded also writes (walk identity, `fill_root`) into the 8-slot context cache. This write is skipped if the identity is already present; otherwise a round-robin slot is used. `lk_ctx_hit`/`lk_root` answer a valid lookup by identity in the same cycle.
- R6: `inv_op` encoding: 0 = unmap page, 1 = device, 2 = global, 3 = flush. A strict unmap (`inv_strict`=1) is accepted when `inv_valid` and `inv_ready` are both 1. The next cycle shows `inv_ready`=0, `inv_done`=1 and `inv_ack_cnt`=1. After that cycle the matching entry no longer hits.
- R7: A lazy unmap (`inv_strict`=0, op 0) is queued without `inv_done`, and the entry keeps hitting until a flush.
- R8: An explicit flush (op 3), or the lazy unmap that fills the 8-deep queue, gives one busy cycle with `inv_done`=1 and `inv_ack_cnt` equal to the number of queued unmaps. All queued pages are removed and the queue is emptied.
- R9: A device invalidation (op 1) removes every translation and context entry of `inv_bdf` and leaves other devices' entries unchanged. It completes like R6 with `inv_ack_cnt`=1.
- R10: A global invalidation (op 2) removes every translation and context entry and completes like R6.
- R11: If the outstanding walk's address is matched by an invalidation in its busy cycle, the walk's fill is discarded. This holds when the fill comes later and when it arrives in that same busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_bdf | input | 16 | Requester identity of the lookup |
| lk_vpn | input | 20 | I/O virtual page number |
| lk_hit | output | 1 | Translation hit |
| lk_ppn | output | 24 | Physical page on hit |
| lk_ctx_hit | output | 1 | Context cache hit |
| lk_root | output | 32 | Page-table root on context hit |
| walk_req | output | 1 | Start a walk for this lookup |
| fill_valid | input | 1 | Walker result for the outstanding walk |
| fill_ppn | input | 24 | Physical page from the walker |
| fill_root | input | 32 | Page-table root from the walker |
| inv_valid | input | 1 | Invalidation request |
| inv_ready | output | 1 | Invalidation port can accept |
| inv_op | input | 2 | 0 unmap, 1 device, 2 global, 3 flush |
| inv_strict | input | 1 | Unmap mode: 1 strict, 0 lazy |
| inv_bdf | input | 16 | Identity for unmap/device |
| inv_vpn | input | 20 | Page for unmap |
| inv_done | output | 1 | Invalidation completes this cycle |
| inv_ack_cnt | output | 4 | Number of unmaps acknowledged |

## Verification
The bench targets the window in which a lazily unmapped page must still hit, and the batch flush that must acknowledge exactly the queued count. A design that flushed early would make the page miss too soon. A design that counted wrongly would report the wrong `inv_ack_cnt`, especially on the auto-flush triggered by the eighth unmap. It also targets fills racing an invalidation, both one cycle later and in the same busy cycle; a design that dropped this check would reinstall a revoked page. Further targets are round-robin eviction after 17 fills and device invalidation, which must spare other devices. A tag compare that ignored the identity would let one device hit another's translation.

// File: rtl/dev_iotlb_pkg.sv
package dev_iotlb_pkg;
    typedef enum logic [1:0] {
        OP_UNMAP  = 2'd0,
        OP_DEV    = 2'd1,
        OP_GLOBAL = 2'd2,
        OP_FLUSH  = 2'd3
    } inv_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CLR  = 1'b1
    } inv_st_e;
endpackage

// File: rtl/dev_iotlb_ctx.sv
// Context cache: requester identity -> page-table root, round-robin.
module dev_iotlb_ctx #(
    parameter int N_CTX  = 8,
    parameter int BDF_W  = 16,
    parameter int ROOT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BDF_W-1:0]  lk_bdf,
    output logic              lk_hit,
    output logic [ROOT_W-1:0] lk_root,
    input  logic              wr_en,
    input  logic [BDF_W-1:0]  wr_bdf,
    input  logic [ROOT_W-1:0] wr_root,
    input  logic              kill_all,
    input  logic              kill_dev,
    input  logic [BDF_W-1:0]  kill_bdf
);
    localparam int PTR_W = (N_CTX > 1) ? $clog2(N_CTX) : 1;

    typedef struct packed {
        logic [N_CTX-1:0]              vld;
        logic [N_CTX-1:0][BDF_W-1:0]   bdf;
        logic [N_CTX-1:0][ROOT_W-1:0]  root;
        logic [PTR_W-1:0]              ptr;
    } ctx_t;

    ctx_t s_d, s_q;
    logic found, wr_seen;

    always_comb begin
        found   = 1'b0;
        lk_root = '0;
        wr_seen = 1'b0;
        for (int i = 0; i < N_CTX; i++) begin
            if (s_q.vld[i] && s_q.bdf[i] == lk_bdf && !found) begin
                found   = 1'b1;
                lk_root = s_q.root[i];
            end
            if (s_q.vld[i] && s_q.bdf[i] == wr_bdf) wr_seen = 1'b1;
        end
        lk_hit = found;

        s_d = s_q;
        for (int i = 0; i < N_CTX; i++) begin
            if (kill_all || (kill_dev && s_q.bdf[i] == kill_bdf)) s_d.vld[i] = 1'b0;
        end
        if (wr_en && !wr_seen) begin
            s_d.vld[s_q.ptr]  = 1'b1;
            s_d.bdf[s_q.ptr]  = wr_bdf;
            s_d.root[s_q.ptr] = wr_root;
            s_d.ptr = (s_q.ptr == PTR_W'(N_CTX - 1)) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dev_iotlb_uq.sv
// Deferred-unmap queue, cleared as a batch.
module dev_iotlb_uq #(
    parameter int Q_DEPTH = 8,
    parameter int BDF_W   = 16,
    parameter int VPN_W   = 20,
    parameter int CNT_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [BDF_W-1:0]                push_bdf,
    input  logic [VPN_W-1:0]                push_vpn,
    input  logic                            clear,
    output logic [CNT_W-1:0]                cnt,
    output logic [Q_DEPTH-1:0]              vld,
    output logic [Q_DEPTH-1:0][BDF_W-1:0]   bdf,
    output logic [Q_DEPTH-1:0][VPN_W-1:0]   vpn
);
    typedef struct packed {
        logic [CNT_W-1:0]              cnt;
        logic [Q_DEPTH-1:0][BDF_W-1:0] bdf;
        logic [Q_DEPTH-1:0][VPN_W-1:0] vpn;
    } uq_t;

    uq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.cnt = '0;
        end else if (push && s_q.cnt < CNT_W'(Q_DEPTH)) begin
            for (int j = 0; j < Q_DEPTH; j++) begin
                if (CNT_W'(j) == s_q.cnt) begin
                    s_d.bdf[j] = push_bdf;
                    s_d.vpn[j] = push_vpn;
                end
            end
            s_d.cnt = s_q.cnt + 1'b1;
        end
        for (int j = 0; j < Q_DEPTH; j++) vld[j] = CNT_W'(j) < s_q.cnt;
        cnt = s_q.cnt;
        bdf = s_q.bdf;
        vpn = s_q.vpn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dev_iotlb.sv
module dev_iotlb
    import dev_iotlb_pkg::*;
#(
    parameter int BDF_W   = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 24,
    parameter int ROOT_W  = 32,
    parameter int N_TLB   = 16,
    parameter int N_CTX   = 8,
    parameter int Q_DEPTH = 8,
    localparam int CNT_W  = $clog2(Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [BDF_W-1:0]  lk_bdf,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_ctx_hit,
    output logic [ROOT_W-1:0] lk_root,
    output logic              walk_req,
    input  logic              fill_valid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [ROOT_W-1:0] fill_root,
    input  logic              inv_valid,
    output logic              inv_ready,
    input  logic [1:0]        inv_op,
    input  logic              inv_strict,
    input  logic [BDF_W-1:0]  inv_bdf,
    input  logic [VPN_W-1:0]  inv_vpn,
    output logic              inv_done,
    output logic [CNT_W-1:0]  inv_ack_cnt
);
    localparam int PTR_W = (N_TLB > 1) ? $clog2(N_TLB) : 1;

    typedef struct packed {
        logic [N_TLB-1:0]             vld;
        logic [N_TLB-1:0][BDF_W-1:0]  bdf;
        logic [N_TLB-1:0][VPN_W-1:0]  vpn;
        logic [N_TLB-1:0][PPN_W-1:0]  ppn;
        logic [PTR_W-1:0]             ptr;
        inv_st_e                      st;
        inv_op_e                      op;
        logic [BDF_W-1:0]             obdf;
        logic [VPN_W-1:0]             ovpn;
        logic                         wpend;
        logic [BDF_W-1:0]             wbdf;
        logic [VPN_W-1:0]             wvpn;
        logic                         stale;
    } tlb_t;

    tlb_t r_d, r_q;
    logic [N_TLB-1:0]              hit_vec;
    logic                          clr, found, walk_kill, fill_ok;
    logic                          q_push, q_clear, ctx_raw;
    logic [CNT_W-1:0]              q_cnt;
    logic [Q_DEPTH-1:0]            q_vld;
    logic [Q_DEPTH-1:0][BDF_W-1:0] q_bdf;
    logic [Q_DEPTH-1:0][VPN_W-1:0] q_vpn;

    assign clr = (r_q.st == ST_CLR);

    // Does the invalidation now being executed cover (b, v)?
    function automatic logic kill_match(input logic [BDF_W-1:0] b, input logic [VPN_W-1:0] v);
        logic m;
        m = 1'b0;
        case (r_q.op)
            OP_UNMAP:  m = (b == r_q.obdf) && (v == r_q.ovpn);
            OP_DEV:    m = (b == r_q.obdf);
            OP_GLOBAL: m = 1'b1;
            default: begin
                for (int j = 0; j < Q_DEPTH; j++)
                    if (q_vld[j] && q_bdf[j] == b && q_vpn[j] == v) m = 1'b1;
            end
        endcase
        return m;
    endfunction

    always_comb begin
        r_d    = r_q;
        found  = 1'b0;
        lk_ppn = '0;
        for (int i = 0; i < N_TLB; i++) begin
            hit_vec[i] = r_q.vld[i] && r_q.bdf[i] == lk_bdf && r_q.vpn[i] == lk_vpn;
            if (hit_vec[i] && lk_valid && !found) begin
                found  = 1'b1;
                lk_ppn = r_q.ppn[i];
            end
        end
        lk_hit      = found;
        lk_ctx_hit  = lk_valid && ctx_raw;
        walk_req    = lk_valid && !found && !r_q.wpend && !clr;
        inv_ready   = !clr;
        inv_done    = clr;
        inv_ack_cnt = !clr ? '0 : (r_q.op == OP_FLUSH) ? q_cnt : CNT_W'(1);

        // walk / fill bookkeeping
        walk_kill = clr && r_q.wpend && kill_match(r_q.wbdf, r_q.wvpn);
        fill_ok   = fill_valid && r_q.wpend && !r_q.stale && !walk_kill;
        if (walk_kill) r_d.stale = 1'b1;
        if (fill_valid && r_q.wpend) r_d.wpend = 1'b0;

        // execute the latched invalidation
        if (clr) begin
            for (int i = 0; i < N_TLB; i++)
                if (kill_match(r_q.bdf[i], r_q.vpn[i])) r_d.vld[i] = 1'b0;
            r_d.st = ST_IDLE;
        end
        q_clear = clr && (r_q.op == OP_FLUSH);

        if (fill_ok) begin
            r_d.vld[r_q.ptr] = 1'b1;
            r_d.bdf[r_q.ptr] = r_q.wbdf;
            r_d.vpn[r_q.ptr] = r_q.wvpn;
            r_d.ppn[r_q.ptr] = fill_ppn;
            r_d.ptr = (r_q.ptr == PTR_W'(N_TLB - 1)) ? '0 : r_q.ptr + 1'b1;
        end

        if (walk_req) begin
            r_d.wpend = 1'b1;
            r_d.wbdf  = lk_bdf;
            r_d.wvpn  = lk_vpn;
            r_d.stale = 1'b0;
        end

        // accept a new invalidation
        q_push = 1'b0;
        if (inv_valid && !clr) begin
            if (inv_op == OP_UNMAP && !inv_strict) begin
                q_push = 1'b1;
                if (q_cnt == CNT_W'(Q_DEPTH - 1)) begin
                    r_d.st = ST_CLR;
                    r_d.op = OP_FLUSH;
                end
            end else begin
                r_d.st   = ST_CLR;
                r_d.op   = inv_op_e'(inv_op);
                r_d.obdf = inv_bdf;
                r_d.ovpn = inv_vpn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    dev_iotlb_ctx #(.N_CTX(N_CTX), .BDF_W(BDF_W), .ROOT_W(ROOT_W)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bdf   (lk_bdf),
        .lk_hit   (ctx_raw),
        .lk_root  (lk_root),
        .wr_en    (fill_ok),
        .wr_bdf   (r_q.wbdf),
        .wr_root  (fill_root),
        .kill_all (clr && r_q.op == OP_GLOBAL),
        .kill_dev (clr && r_q.op == OP_DEV),
        .kill_bdf (r_q.obdf)
    );

    dev_iotlb_uq #(.Q_DEPTH(Q_DEPTH), .BDF_W(BDF_W), .VPN_W(VPN_W), .CNT_W(CNT_W)) u_uq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_bdf (inv_bdf),
        .push_vpn (inv_vpn),
        .clear    (q_clear),
        .cnt      (q_cnt),
        .vld      (q_vld),
        .bdf      (q_bdf),
        .vpn      (q_vpn)
    );
endmodule

// File: rtl/dev_iotlb_chk.sv
module dev_iotlb_chk #(
    parameter int N_TLB   = 16,
    parameter int Q_DEPTH = 8,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_hit,
    input logic             lk_ctx_hit,
    input logic             walk_req,
    input logic             inv_valid,
    input logic             inv_ready,
    input logic [1:0]       inv_op,
    input logic             inv_strict,
    input logic             inv_done,
    input logic [CNT_W-1:0] inv_ack_cnt,
    input logic [N_TLB-1:0] hit_vec,
    input logic [CNT_W-1:0] q_cnt
);
    // R2 / R4: a fill never creates a second copy of a tag
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R3: one outstanding walk only
    a_r3_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |=> !walk_req);

    // R6: synchronous operations stall the port and complete next cycle
    a_r6_sync_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_ready && (inv_strict || inv_op != 2'd0)) |=> (!inv_ready && inv_done));

    // R7: a lazy unmap below the fill mark gives no completion
    a_r7_lazy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_ready && !inv_strict && inv_op == 2'd0 && q_cnt < CNT_W'(Q_DEPTH - 1))
        |=> (inv_ready && !inv_done));

    // R8: the unmap that fills the queue triggers a flush acknowledging all of it
    a_r8_full_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_ready && !inv_strict && inv_op == 2'd0 && q_cnt == CNT_W'(Q_DEPTH - 1))
        |=> (inv_done && inv_ack_cnt == CNT_W'(Q_DEPTH)));

    // R10: nothing hits once a global invalidation has run
    a_r10_global_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_ready && inv_op == 2'd2) |=> ##1 (!lk_hit && !lk_ctx_hit));
endmodule

bind dev_iotlb dev_iotlb_chk #(.N_TLB(N_TLB), .Q_DEPTH(Q_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_hit      (lk_hit),
    .lk_ctx_hit  (lk_ctx_hit),
    .walk_req    (walk_req),
    .inv_valid   (inv_valid),
    .inv_ready   (inv_ready),
    .inv_op      (inv_op),
    .inv_strict  (inv_strict),
    .inv_done    (inv_done),
    .inv_ack_cnt (inv_ack_cnt),
    .hit_vec     (hit_vec),
    .q_cnt       (q_cnt)
);

// File: tb/dev_iotlb_tb.sv
module dev_iotlb_tb;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 0, fill_valid = 0, inv_valid = 0, inv_strict = 0;
    logic [15:0] lk_bdf = 0, inv_bdf = 0;
    logic [19:0] lk_vpn = 0, inv_vpn = 0;
    logic [23:0] fill_ppn = 0;
    logic [31:0] fill_root = 0;
    logic [1:0]  inv_op = 0;
    logic lk_hit, lk_ctx_hit, walk_req, inv_ready, inv_done;
    logic [23:0] lk_ppn;
    logic [31:0] lk_root;
    logic [3:0]  inv_ack_cnt;

    int n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    dev_iotlb u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_bdf(lk_bdf), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ctx_hit(lk_ctx_hit), .lk_root(lk_root),
        .walk_req(walk_req), .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_root(fill_root),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_op(inv_op), .inv_strict(inv_strict),
        .inv_bdf(inv_bdf), .inv_vpn(inv_vpn), .inv_done(inv_done), .inv_ack_cnt(inv_ack_cnt)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_v[16];
    logic [15:0] m_b[16];
    logic [19:0] m_vp[16];
    logic [23:0] m_p[16];
    int          m_ptr;
    bit          c_v[8];
    logic [15:0] c_b[8];
    logic [31:0] c_r[8];
    int          c_ptr;
    logic [15:0] q_b[$];
    logic [19:0] q_v[$];
    bit          m_busy, m_pend, m_stale;
    int          m_op;
    logic [15:0] m_ob, m_wb;
    logic [19:0] m_ov, m_wv;
    // expected outputs
    bit          e_hit, e_ctx, e_walk, e_ready, e_done;
    logic [23:0] e_ppn;
    logic [31:0] e_root;
    int          e_ack;
    bit          u_fill, u_ctx_seen;

    function automatic bit mkill(input logic [15:0] b, input logic [19:0] v);
        bit m = 0;
        case (m_op)
            0: m = (b == m_ob) && (v == m_ov);
            1: m = (b == m_ob);
            2: m = 1;
            default: foreach (q_b[j]) if (q_b[j] == b && q_v[j] == v) m = 1;
        endcase
        return m;
    endfunction

    task automatic model_exp();
        e_hit = 0; e_ppn = 0; e_ctx = 0; e_root = 0;
        for (int i = 0; i < 16; i++)
            if (lk_valid && m_v[i] && m_b[i] == lk_bdf && m_vp[i] == lk_vpn && !e_hit) begin
                e_hit = 1; e_ppn = m_p[i];
            end
        for (int i = 0; i < 8; i++)
            if (lk_valid && c_v[i] && c_b[i] == lk_bdf && !e_ctx) begin
                e_ctx = 1; e_root = c_r[i];
            end
        e_walk  = lk_valid && !e_hit && !m_pend && !m_busy;
        e_ready = !m_busy;
        e_done  = m_busy;
        e_ack   = (m_op == 3) ? q_b.size() : 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_v[i]) m_v[i] = 0;
            foreach (c_v[i]) c_v[i] = 0;
            m_ptr = 0; c_ptr = 0; q_b.delete(); q_v.delete();
            m_busy = 0; m_pend = 0; m_stale = 0; m_op = 0;
        end else begin
            model_exp();
            u_fill = fill_valid && m_pend && !(m_stale || (m_busy && mkill(m_wb, m_wv)));
            u_ctx_seen = 0;
            for (int i = 0; i < 8; i++) if (c_v[i] && c_b[i] == m_wb) u_ctx_seen = 1;
            if (m_busy && m_pend && mkill(m_wb, m_wv)) m_stale = 1;
            if (fill_valid && m_pend) m_pend = 0;
            if (m_busy) begin
                for (int i = 0; i < 16; i++) if (mkill(m_b[i], m_vp[i])) m_v[i] = 0;
                for (int i = 0; i < 8; i++)
                    if (m_op == 2 || (m_op == 1 && c_b[i] == m_ob)) c_v[i] = 0;
                if (m_op == 3) begin q_b.delete(); q_v.delete(); end
                m_busy = 0;
            end
            if (u_fill) begin
                m_v[m_ptr] = 1; m_b[m_ptr] = m_wb; m_vp[m_ptr] = m_wv; m_p[m_ptr] = fill_ppn;
                m_ptr = (m_ptr + 1) % 16;
                if (!u_ctx_seen) begin
                    c_v[c_ptr] = 1; c_b[c_ptr] = m_wb; c_r[c_ptr] = fill_root;
                    c_ptr = (c_ptr + 1) % 8;
                end
            end
            if (e_walk) begin m_pend = 1; m_wb = lk_bdf; m_wv = lk_vpn; m_stale = 0; end
            if (inv_valid && e_ready) begin
                if (inv_op == 0 && !inv_strict) begin
                    q_b.push_back(inv_bdf); q_v.push_back(inv_vpn);
                    if (q_b.size() == 8) begin m_busy = 1; m_op = 3; end
                end else begin
                    m_busy = 1; m_op = int'(inv_op); m_ob = inv_bdf; m_ov = inv_vpn;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            model_exp();
            chk(lk_hit == e_hit, "R2 lk_hit", lk_hit, e_hit);
            if (e_hit) chk(lk_ppn == e_ppn, "R4 lk_ppn", lk_ppn, e_ppn);
            chk(lk_ctx_hit == e_ctx, "R5 lk_ctx_hit", lk_ctx_hit, e_ctx);
            if (e_ctx) chk(lk_root == e_root, "R5 lk_root", lk_root, e_root);
            chk(walk_req == e_walk, "R3 walk_req", walk_req, e_walk);
            chk(inv_ready == e_ready, "R6 inv_ready", inv_ready, e_ready);
            chk(inv_done == e_done, "R8 inv_done", inv_done, e_done);
            if (e_done) chk(int'(inv_ack_cnt) == e_ack, "R8 inv_ack_cnt", inv_ack_cnt, e_ack);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(); @(posedge clk); #1; endtask

    task automatic walk(input logic [15:0] b, input logic [19:0] v,
                        input logic [23:0] p, input logic [31:0] r);
        lk_valid = 1; lk_bdf = b; lk_vpn = v;
        @(negedge clk);
        chk(walk_req == 1'b1, "R3 walk on miss", walk_req, 1);
        tick();
        lk_valid = 0; fill_valid = 1; fill_ppn = p; fill_root = r;
        tick();
        fill_valid = 0;
    endtask

    task automatic look(input logic [15:0] b, input logic [19:0] v,
                        input bit eh, input logic [23:0] ep, input string tag);
        lk_valid = 1; lk_bdf = b; lk_vpn = v;
        @(negedge clk);
        chk(lk_hit == eh, tag, lk_hit, eh);
        if (eh) chk(lk_ppn == ep, tag, lk_ppn, ep);
        #1 lk_valid = 0;
        tick();
    endtask

    task automatic look_ctx(input logic [15:0] b, input bit eh, input logic [31:0] er, input string tag);
        lk_valid = 1; lk_bdf = b; lk_vpn = 20'hFFFFF;
        @(negedge clk);
        chk(lk_ctx_hit == eh, tag, lk_ctx_hit, eh);
        if (eh) chk(lk_root == er, tag, lk_root, er);
        #1 lk_valid = 0;
        tick();
    endtask

    task automatic inv_go(input int op, input bit strict, input logic [15:0] b, input logic [19:0] v);
        inv_valid = 1; inv_op = 2'(op); inv_strict = strict; inv_bdf = b; inv_vpn = v;
        tick();
        inv_valid = 0;
    endtask

    task automatic inv_sync(input int op, input bit strict, input logic [15:0] b,
                            input logic [19:0] v, input int ack, input string tag);
        inv_go(op, strict, b, v);
        @(negedge clk);
        chk(inv_done && !inv_ready, tag, {inv_done, inv_ready}, 2'b10);
        chk(int'(inv_ack_cnt) == ack, tag, inv_ack_cnt, ack);
        tick();
    endtask

    task automatic inv_lazy(input logic [15:0] b, input logic [19:0] v);
        inv_go(0, 0, b, v);
        @(negedge clk);
        chk(!inv_done && inv_ready, "R7 lazy no done", {inv_done, inv_ready}, 2'b01);
        tick();
    endtask

    // ---------------- test sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        look(16'h0100, 20'd1, 0, 0, "R1 reset miss");
        look_ctx(16'h0100, 0, 0, "R1 reset ctx miss");
        chk(inv_ready == 1'b1, "R1 ready", inv_ready, 1);

        walk(16'h0100, 20'd1, 24'hA00001, 32'hB000_0100);
        look(16'h0100, 20'd1, 1, 24'hA00001, "R2 hit after fill");
        look(16'h0101, 20'd1, 0, 0, "R2 other device misses");
        look(16'h0100, 20'd2, 0, 0, "R2 other page misses");
        look_ctx(16'h0100, 1, 32'hB000_0100, "R5 ctx root");

        // round-robin replacement over 17 consecutive fills
        for (int k = 0; k < 17; k++) walk(16'h0200, 20'(k), 24'h200000 + 24'(k), 32'hC000_0200);
        look(16'h0200, 20'd0, 0, 0, "R4 oldest evicted");
        look(16'h0200, 20'd1, 1, 24'h200001, "R4 next kept");
        look(16'h0200, 20'd16, 1, 24'h200010, "R4 newest kept");

        // context cache round robin over 9 new identities
        for (int k = 0; k < 9; k++) walk(16'h0300 + 16'(k), 20'd7, 24'h300000 + 24'(k), 32'hD000_0000 + 32'(k));
        look_ctx(16'h0300, 0, 0, "R5 ctx oldest evicted");
        look_ctx(16'h0308, 1, 32'hD000_0008, "R5 ctx newest");

        // strict unmap
        inv_sync(0, 1, 16'h0302, 20'd7, 1, "R6 strict done");
        look(16'h0302, 20'd7, 0, 0, "R6 unmapped misses");
        look(16'h0303, 20'd7, 1, 24'h300003, "R6 neighbour kept");

        // lazy unmaps then explicit flush
        inv_lazy(16'h0303, 20'd7);
        inv_lazy(16'h0304, 20'd7);
        inv_lazy(16'h0305, 20'd7);
        look(16'h0303, 20'd7, 1, 24'h300003, "R7 still hits before flush");
        inv_sync(3, 0, 16'h0000, 20'd0, 3, "R8 flush ack 3");
        look(16'h0304, 20'd7, 0, 0, "R8 flushed page misses");

        // eighth lazy unmap triggers the batch flush
        for (int k = 0; k < 7; k++) inv_lazy(16'h0306, 20'd7);
        inv_go(0, 0, 16'h0307, 20'd7);
        @(negedge clk);
        chk(inv_done && int'(inv_ack_cnt) == 8, "R8 auto flush ack 8", inv_ack_cnt, 8);
        tick();
        look(16'h0307, 20'd7, 0, 0, "R8 auto flushed misses");
        inv_sync(3, 0, 16'h0000, 20'd0, 0, "R8 empty flush ack 0");

        // device invalidation
        walk(16'h0400, 20'd1, 24'h400001, 32'hE000_0400);
        walk(16'h0400, 20'd2, 24'h400002, 32'hE000_0400);
        walk(16'h0401, 20'd1, 24'h400101, 32'hE000_0401);
        inv_sync(1, 1, 16'h0400, 20'd0, 1, "R9 device done");
        look(16'h0400, 20'd2, 0, 0, "R9 device page gone");
        look(16'h0401, 20'd1, 1, 24'h400101, "R9 other device kept");
        look_ctx(16'h0400, 0, 0, "R9 device ctx gone");
        look_ctx(16'h0401, 1, 32'hE000_0401, "R9 other ctx kept");

        // stale fill: invalidated one cycle before the fill
        lk_valid = 1; lk_bdf = 16'h0500; lk_vpn = 20'd3; tick(); lk_valid = 0;
        inv_go(0, 1, 16'h0500, 20'd3);
        tick();
        fill_valid = 1; fill_ppn = 24'h500003; fill_root = 32'hF000_0500; tick(); fill_valid = 0;
        look(16'h0500, 20'd3, 0, 0, "R11 late fill discarded");
        // stale fill: arrives in the busy cycle itself
        lk_valid = 1; lk_bdf = 16'h0501; lk_vpn = 20'd4; tick(); lk_valid = 0;
        inv_go(1, 1, 16'h0501, 20'd0);
        fill_valid = 1; fill_ppn = 24'h500104; fill_root = 32'hF000_0501; tick(); fill_valid = 0;
        look(16'h0501, 20'd4, 0, 0, "R11 same-cycle fill discarded");
        look_ctx(16'h0501, 0, 0, "R11 ctx not written");

        // global invalidation
        inv_sync(2, 1, 16'h0000, 20'd0, 1, "R10 global done");
        look(16'h0401, 20'd1, 0, 0, "R10 all gone");
        look(16'h0200, 20'd16, 0, 0, "R10 all gone 2");
        look_ctx(16'h0100, 0, 0, "R10 ctx gone");
        walk(16'h0600, 20'd9, 24'h600009, 32'h1234_5678);
        look(16'h0600, 20'd9, 1, 24'h600009, "R4 refill after global");

        repeat (2) tick();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule